// File: doc/BRIEF.md
# Biquinary Decade Counter

This block is a four-bit counter built from two stages that share one system clock. A single toggle stage drives output bit A. A modulo-five stage drives output bits B, C and D. Each stage has its own count input. A count event on that input is its high-to-low transition, found by registering the input on the system clock. A two-bit mode input sets how the stages are chained. They can run as two independent dividers, as a natural-binary decade counter, or as a divide-by-ten whose A output is a symmetric square wave.

Two clear inputs are combined by AND and force the whole count to zero. Two preset inputs are also combined by AND and force the count to nine, for nine's-complement decimal use. Preset wins over clear, and both win over any count event in the same cycle. Several decades can be cascaded from outside the block by feeding an output bit into the count input of the next decade.

Top module: `bq_decade_top`

## Requirements
- R1: After the asynchronous active-low reset is released, the output q_o (bit 3 = D, bit 2 = C, bit 1 = B, bit 0 = A) reads 4'b0000.
- R2: With clr_i == 2'b11 and pre_i != 2'b11 on a clock edge, q_o becomes 4'b0000. A single high clear bit (2'b01 or 2'b10) leaves q_o unchanged.
- R3: With pre_i == 2'b11 on a clock edge, q_o becomes 4'b1001 whatever clr_i holds.
- R4: While clr_i == 2'b11 or pre_i == 2'b11, count events do not advance the counter. Without a count event, clear or preset, q_o holds its value.
- R5: A count event is a high-to-low transition of a count input. A rising transition or a steady level leaves q_o unchanged. The falling transition advances q_o within three clock cycles of being sampled low.
- R6: In mode_i == 2'b01, falling edges on cnt_a_i step q_o through 0 to 9 in natural binary and wrap from 9 to 0. Output A falling from 1 to 0 steps the modulo-five stage in the same cycle. cnt_b_i has no effect.
- R7: In mode_i == 2'b10, falling edges on cnt_b_i step the modulo-five stage. Its 4-to-0 wrap toggles A in the same cycle. A is therefore low for five counts and high for five, and the q_o sequence is 0,2,4,6,8,1,3,5,7,9. cnt_a_i has no effect.
- R8: In mode_i == 2'b00 or 2'b11, A toggles on each cnt_a_i event. {D,C,B} counts 0,1,2,3,4 and wraps on cnt_b_i events. The two stages do not affect each other.
- R9: After a preset to nine, the next count in decade mode returns q_o to 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_a_i | input | 1 | Count input of the toggle stage |
| cnt_b_i | input | 1 | Count input of the modulo-five stage |
| clr_i | input | 2 | Clear-to-zero pair, active when both bits are high |
| pre_i | input | 2 | Preset-to-nine pair, active when both bits are high |
| mode_i | input | 2 | Chaining select: 00/11 independent, 01 decade, 10 symmetric divide-by-ten |
| q_o | output | 4 | Count as {D,C,B,A} |

## Verification
The chaining assertions assume that mode_i stays steady while counting runs, so the mode decoded in one cycle still applies in the next. The bench changes the mode only while the count inputs are idle, and it loads a known value right after each change. The edge-detector assertion assumes that a count input holds each level for at least two clock cycles. Every stimulus task keeps each level for three or more cycles, so no transition can be missed.

// File: rtl/bq_pkg.sv
`timescale 1ns/1ps
package bq_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT = 2'b00,
    MODE_DEC   = 2'b01,
    MODE_SYM   = 2'b10,
    MODE_ALT   = 2'b11
  } bq_mode_e;

  localparam int unsigned QUINARY_W    = 3;
  localparam int unsigned QUINARY_LAST = 4;
  localparam int unsigned N_CNT_IN     = 2;
endpackage

// File: rtl/bq_fall_det.sv
`timescale 1ns/1ps
module bq_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] shr_q;
  logic [STAGES-1:0] shr_d;

  always_comb begin
    shr_d = {shr_q[STAGES-2:0], sig_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shr_q <= '0;
    else         shr_q <= shr_d;
  end

  assign fall_o = shr_q[TOP] & ~shr_q[TOP-1];

  // R5
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/bq_div2.sv
`timescale 1ns/1ps
module bq_div2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic step_i,
  output logic q_o,
  output logic fall_o
);
  logic q_q, q_d, en;

  always_comb begin
    en  = set_i | clr_i | step_i;
    q_d = q_q;
    if (set_i)       q_d = 1'b1;
    else if (clr_i)  q_d = 1'b0;
    else if (step_i) q_d = ~q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_q <= 1'b0;
    else if (en)  q_q <= q_d;
  end

  assign q_o    = q_q;
  assign fall_o = step_i & q_q & ~set_i & ~clr_i;

  // R8
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !set_i && !clr_i) |=> (q_o != $past(q_o)));
endmodule

// File: rtl/bq_div5.sv
`timescale 1ns/1ps
module bq_div5 import bq_pkg::*; (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic                 clr_i,
  input  logic                 step_i,
  output logic [QUINARY_W-1:0] q_o,
  output logic                 wrap_o
);
  localparam logic [QUINARY_W-1:0] LAST = QUINARY_W'(QUINARY_LAST);

  logic [QUINARY_W-1:0] st_q, st_d;
  logic en;

  always_comb begin
    en   = set_i | clr_i | step_i;
    st_d = st_q;
    if (set_i)       st_d = LAST;
    else if (clr_i)  st_d = '0;
    else if (step_i) st_d = (st_q >= LAST) ? '0 : st_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  st_q <= '0;
    else if (en)  st_q <= st_d;
  end

  assign q_o    = st_q;
  assign wrap_o = step_i & st_q[QUINARY_W-1] & ~set_i & ~clr_i;

  // R8
  in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q <= LAST);

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i || clr_i || step_i) |=> $stable(st_q));
endmodule

// File: rtl/bq_decade_top.sv
`timescale 1ns/1ps
module bq_decade_top import bq_pkg::*; #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cnt_a_i,
  input  logic       cnt_b_i,
  input  logic [1:0] clr_i,
  input  logic [1:0] pre_i,
  input  logic [1:0] mode_i,
  output logic [3:0] q_o
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_STAGES-1];

  logic [N_CNT_IN-1:0] cnt_raw, cnt_fall;
  assign cnt_raw = {cnt_b_i, cnt_a_i};

  for (genvar g = 0; g < N_CNT_IN; g++) begin : g_edge
    bq_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
      .clk_i (clk_i),
      .rst_ni(rst_n_s),
      .sig_i (cnt_raw[g]),
      .fall_o(cnt_fall[g])
    );
  end

  logic load_nine, load_zero;
  logic step_a, step_b;
  logic a_q, a_fall, m_wrap;
  logic [QUINARY_W-1:0] m_q;
  bq_mode_e mode;

  always_comb begin
    mode      = bq_mode_e'(mode_i);
    load_nine = &pre_i;
    load_zero = &clr_i;
    unique case (mode)
      MODE_DEC: begin
        step_a = cnt_fall[0];
        step_b = cnt_fall[0] & a_q;
      end
      MODE_SYM: begin
        step_b = cnt_fall[1];
        step_a = m_wrap;
      end
      default: begin
        step_a = cnt_fall[0];
        step_b = cnt_fall[1];
      end
    endcase
  end

  bq_div2 u_two (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .set_i (load_nine),
    .clr_i (load_zero),
    .step_i(step_a),
    .q_o   (a_q),
    .fall_o(a_fall)
  );

  bq_div5 u_five (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .set_i (load_nine),
    .clr_i (load_zero),
    .step_i(step_b),
    .q_o   (m_q),
    .wrap_o(m_wrap)
  );

  assign q_o = {m_q, a_q};

  // R3
  preset_nine_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    load_nine |=> (q_o == 4'b1001));

  // R2
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (load_zero && !load_nine) |=> (q_o == 4'b0000));

  // R6
  dec_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (mode == MODE_DEC && a_fall && !load_nine && !load_zero)
      |=> (m_q != $past(m_q)));

  // R9
  dec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (mode == MODE_DEC && cnt_fall[0] && q_o == 4'd9 && !load_nine && !load_zero)
      |=> (q_o == 4'd0));
endmodule

// File: tb/bq_decade_top_bench.sv
`timescale 1ns/1ps
module bq_decade_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_a, cnt_b;
  logic [1:0] clr, pre, mode;
  logic [3:0] q;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  bq_decade_top u_bq_decade_top (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .cnt_a_i(cnt_a),
    .cnt_b_i(cnt_b),
    .clr_i  (clr),
    .pre_i  (pre),
    .mode_i (mode),
    .q_o    (q)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_a();
    @(negedge clk) cnt_a = 1'b1;
    repeat (3) @(negedge clk);
    cnt_a = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_b();
    @(negedge clk) cnt_b = 1'b1;
    repeat (3) @(negedge clk);
    cnt_b = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 2'b11;
    @(negedge clk) clr = 2'b00;
  endtask

  task automatic do_preset();
    @(negedge clk) pre = 2'b11;
    @(negedge clk) pre = 2'b00;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cnt_a = 0; cnt_b = 0; clr = 0; pre = 0; mode = 2'b01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset value", q, 4'b0000);
  endtask

  task automatic t_decade();
    mode = 2'b01;
    do_clear();
    for (int k = 1; k <= 12; k++) begin
      pulse_a();
      chk("R6 decade step", q, 4'((k) % 10));
    end
    pulse_b();
    chk("R6 cnt_b ignored in decade mode", q, 4'd2);
  endtask

  task automatic t_symmetric();
    int m = 0;
    int a = 0;
    mode = 2'b10;
    do_clear();
    for (int k = 1; k <= 11; k++) begin
      pulse_b();
      if (m == 4) begin m = 0; a ^= 1; end
      else m++;
      chk("R7 symmetric step", q, 4'((m << 1) | a));
    end
    pulse_a();
    chk("R7 cnt_a ignored in symmetric mode", q, 4'((m << 1) | a));
    do_preset();
    pulse_b();
    chk("R7 wrap from nine", q, 4'b0000);
  endtask

  task automatic t_split(input logic [1:0] md);
    mode = md;
    do_clear();
    pulse_a();
    chk("R8 A toggles", q, 4'b0001);
    for (int k = 1; k <= 6; k++) begin
      pulse_b();
      chk("R8 quinary step", q, 4'(((k % 5) << 1) | 1));
    end
    pulse_a();
    chk("R8 A toggles back, quinary kept", q, 4'b0010);
  endtask

  task automatic t_loads();
    mode = 2'b01;
    do_clear();
    pulse_a(); pulse_a(); pulse_a();
    @(negedge clk) clr = 2'b10;
    @(negedge clk) clr = 2'b01;
    @(negedge clk) clr = 2'b00;
    chk("R2 single clear bit no effect", q, 4'd3);
    do_clear();
    chk("R2 clear to zero", q, 4'b0000);
    @(negedge clk) begin pre = 2'b11; clr = 2'b11; end
    @(negedge clk) begin pre = 2'b00; clr = 2'b00; end
    chk("R3 preset wins over clear", q, 4'b1001);
    pulse_a();
    chk("R9 nine then zero", q, 4'b0000);
    @(negedge clk) clr = 2'b11;
    pulse_a();
    chk("R4 clear held blocks count", q, 4'b0000);
    clr = 2'b00;
    @(negedge clk) pre = 2'b11;
    pulse_a();
    chk("R4 preset held blocks count", q, 4'b1001);
    pre = 2'b00;
    repeat (5) @(negedge clk);
    chk("R4 holds without events", q, 4'b1001);
  endtask

  task automatic t_edge();
    mode = 2'b01;
    do_clear();
    @(negedge clk) cnt_a = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5 rising edge no count", q, 4'b0000);
    cnt_a = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 falling edge counts", q, 4'b0001);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_decade();
    t_symmetric();
    t_split(2'b00);
    t_split(2'b11);
    t_loads();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule